// File: doc/BRIEF.md
# Odd-Width Significand Multiplier

This block multiplies two unsigned operands of an odd width N (13 or 53 in floating-point use) and returns the full 2N-bit product. A product of that width is what a significand datapath needs. It is purely combinational: the product follows the operands with no clock and no state.

Each operand is split into its top bit and an (N-1)-bit remainder. Only the two remainders go through a real multiplier core. The core is an (N-1)-by-(N-1) unit, and a parameter chooses its form: a single flat behavioural product, or four half-width products joined by shifted additions.

Each cross term needs no multiplier. It is the other operand's remainder, passed through a 2:1 select that is steered by the top bit of one operand. Two (N-1)-bit adders and one full adder join the cross terms and the top-bit product to the core result. This avoids widening the operands to an even width only to suit an even split.

Top module: `prime_sig_mul`

## Requirements
- R1: For every pair of operands `op_a`, `op_b`, the output `prod` equals their unsigned product `op_a * op_b` over all 2N bits.
- R2: Bits N-2 down to 0 of `prod` equal bits N-2 down to 0 of the product of the two operand remainders `op_a[N-2:0] * op_b[N-2:0]`.
- R3: When bit N-1 of both operands is 0, bits 2N-1 and 2N-2 of `prod` are both 0.
- R4: When either operand is zero, `prod` is zero.
- R5: When both operands carry only bit N-1, `prod` has exactly one bit set, at position 2N-2.
- R6: When both operands are all ones, `prod` equals 2^(2N) - 2^(N+1) + 1.
- R7: Bit 2N-1 of `prod` is 1 only if bit N-1 is 1 in both operands.
- R8: R1 holds with either core form, the flat product (CORE_FLAT) or the half-split product (CORE_HALVES), and for N = 5, 13 and 53.
- R9: A change on the operands appears on `prod` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand; bit N-1 is the separated top bit |
| op_b | input | N | Unsigned multiplier; bit N-1 is the separated top bit |
| prod | output | 2N | Unsigned full-width product |

## Verification
Two paths can act on the top product bits in the same evaluation. The first is the carry out of the cross-term adder. The second is the carry out of the adder that folds the upper half of the core product, and both of these carries can arise from one operand pair. The same full adder then takes in the top-bit product as well. The bench provokes this case with all-ones operands, which make both carries and the top-bit AND 1 together. It also covers every pair at N = 5, where both carries occur in many combinations. Each result is compared with a product the bench computes at full width.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic [0:0] {
    CORE_FLAT   = 1'b0,
    CORE_HALVES = 1'b1
  } core_kind_e;
endpackage

// File: rtl/psm_xgate.sv
module psm_xgate #(
  parameter int W = 12
) (
  input  logic         sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_comb begin
    if (sel) dout = din;
    else     dout = '0;
  end
endmodule

// File: rtl/psm_add.sv
module psm_add #(
  parameter int W = 12
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] total;
  assign total = {1'b0, x} + {1'b0, y};
  assign sum   = total[W-1:0];
  assign cout  = total[W];
endmodule

// File: rtl/psm_fa.sv
module psm_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/psm_core.sv
module psm_core
  import psm_pkg::*;
#(
  parameter int         W    = 12,
  parameter core_kind_e KIND = CORE_HALVES
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (KIND == CORE_HALVES && (W % 2 == 0) && W >= 2) begin : g_halves
      logic [H-1:0]   xl, xh, yl, yh;
      logic [2*H-1:0] pll, plh, phl, phh;
      logic [2*H:0]   mid;
      logic [2*W-1:0] mid_ext;
      assign xl = x[H-1:0];
      assign xh = x[W-1:H];
      assign yl = y[H-1:0];
      assign yh = y[W-1:H];
      assign pll = {{H{1'b0}}, xl} * {{H{1'b0}}, yl};
      assign plh = {{H{1'b0}}, xl} * {{H{1'b0}}, yh};
      assign phl = {{H{1'b0}}, xh} * {{H{1'b0}}, yl};
      assign phh = {{H{1'b0}}, xh} * {{H{1'b0}}, yh};
      assign mid = {1'b0, plh} + {1'b0, phl};
      assign mid_ext = {{(W-1){1'b0}}, mid} << H;
      assign p = {phh, pll} + mid_ext;
    end else begin : g_flat
      assign p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    end
  endgenerate
endmodule

// File: rtl/prime_sig_mul.sv
module prime_sig_mul
  import psm_pkg::*;
#(
  parameter int         N    = 53,
  parameter core_kind_e KIND = CORE_HALVES
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);
  localparam int W = N - 1;

  logic         a_top, b_top;
  logic [W-1:0] a_rem, b_rem;
  logic [2*W-1:0] core_p;
  logic [W-1:0] x_from_a, x_from_b;
  logic [W-1:0] s1, s2;
  logic         c1, c2, s3, c3;

  assign a_top = op_a[N-1];
  assign b_top = op_b[N-1];
  assign a_rem = op_a[W-1:0];
  assign b_rem = op_b[W-1:0];

  psm_core #(.W(W), .KIND(KIND)) u_core (
    .x(a_rem), .y(b_rem), .p(core_p)
  );

  psm_xgate #(.W(W)) u_xa (.sel(a_top), .din(b_rem), .dout(x_from_a));
  psm_xgate #(.W(W)) u_xb (.sel(b_top), .din(a_rem), .dout(x_from_b));

  psm_add #(.W(W)) u_add_cross (
    .x(x_from_a), .y(x_from_b), .sum(s1), .cout(c1)
  );
  psm_add #(.W(W)) u_add_fold (
    .x(s1), .y(core_p[2*W-1:W]), .sum(s2), .cout(c2)
  );

  psm_fa u_fa (.x(c1), .y(c2), .z(a_top & b_top), .s(s3), .c(c3));

  assign prod = {c3, s3, s2, core_p[W-1:0]};
endmodule

// File: rtl/prime_sig_mul_chk.sv
module prime_sig_mul_chk #(
  parameter int N = 53
) (
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);
  logic [2*N-1:0] ref_full;
  logic [2*N-3:0] ref_rem;
  assign ref_full = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
  assign ref_rem  = {{(N-1){1'b0}}, op_a[N-2:0]} * {{(N-1){1'b0}}, op_b[N-2:0]};

  always_comb begin
    // R1
    full_product_chk: assert (prod == ref_full);
    // R2
    low_half_chk: assert (prod[N-2:0] == ref_rem[N-2:0]);
    // R3
    if (!op_a[N-1] && !op_b[N-1])
      top_clear_chk: assert (prod[2*N-1:2*N-2] == 2'b00);
    // R4
    if (op_a == '0 || op_b == '0)
      zero_operand_chk: assert (prod == '0);
    // R7
    if (prod[2*N-1])
      top_bit_source_chk: assert (op_a[N-1] && op_b[N-1]);
  end
endmodule

bind prime_sig_mul prime_sig_mul_chk #(.N(N)) u_chk (
  .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/test_prime_sig_mul.sv
module test_prime_sig_mul;
  import psm_pkg::*;

  logic clk;
  logic rst_n;
  int   n_checks;
  int   n_errors;

  logic [4:0]   a5, b5;
  logic [9:0]   p5;
  logic [12:0]  a13, b13;
  logic [25:0]  p13;
  logic [52:0]  a53, b53;
  logic [105:0] p53;

  prime_sig_mul #(.N(53), .KIND(CORE_HALVES)) i_prime_sig_mul (
    .op_a(a53), .op_b(b53), .prod(p53)
  );
  prime_sig_mul #(.N(5), .KIND(CORE_HALVES)) i_prime_sig_mul_n5 (
    .op_a(a5), .op_b(b5), .prod(p5)
  );
  prime_sig_mul #(.N(13), .KIND(CORE_FLAT)) i_prime_sig_mul_n13 (
    .op_a(a13), .op_b(b13), .prod(p13)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset_state;
    @(posedge clk);
    a5 = '0; b5 = '0; a13 = '0; b13 = '0; a53 = '0; b53 = '0;
    @(negedge clk);
    // R4: zero operands give zero product
    check("R4 reset n5", 128'(p5), 128'd0);
    check("R4 reset n13", 128'(p13), 128'd0);
    check("R4 reset n53", 128'(p53), 128'd0);
  endtask

  task automatic t_exhaustive5;
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        @(posedge clk);
        a5 = 5'(i); b5 = 5'(j);
        @(negedge clk);
        // R1 full product, R8 for N=5
        check("R1 n5", 128'(p5), 128'(i * j));
        // R2 low bits from remainder product
        check("R2 n5", 128'(p5[3:0]), 128'(((i % 16) * (j % 16)) % 16));
        // R3 top bits clear when both top bits clear
        if (i < 16 && j < 16) check("R3 n5", 128'(p5[9:8]), 128'd0);
        // R7 bit 9 needs both top bits
        if (!(i >= 16 && j >= 16)) check("R7 n5", 128'(p5[9]), 128'd0);
      end
    end
  endtask

  task automatic t_msb_only;
    @(posedge clk);
    a5 = 5'h10; b5 = 5'h10;
    a13 = 13'h1000; b13 = 13'h1000;
    a53 = 53'd1 << 52; b53 = 53'd1 << 52;
    @(negedge clk);
    // R5 single bit at 2N-2
    check("R5 n5", 128'(p5), 128'd1 << 8);
    check("R5 n13", 128'(p13), 128'd1 << 24);
    check("R5 n53", 128'(p53), 128'd1 << 104);
  endtask

  task automatic t_all_ones;
    logic [127:0] e;
    @(posedge clk);
    a5 = '1; b5 = '1; a13 = '1; b13 = '1; a53 = '1; b53 = '1;
    @(negedge clk);
    // R6 all-ones square; both adder carries and top AND coincide
    e = (128'd1 << 10) - (128'd1 << 6) + 128'd1;
    check("R6 n5", 128'(p5), e);
    e = (128'd1 << 26) - (128'd1 << 14) + 128'd1;
    check("R6 n13", 128'(p13), e);
    e = (128'd1 << 106) - (128'd1 << 54) + 128'd1;
    check("R6 n53", 128'(p53), e);
  endtask

  task automatic t_zero_one;
    @(posedge clk);
    a53 = '0; b53 = '1; a13 = 13'h1abc; b13 = '0;
    @(negedge clk);
    // R4 one operand zero
    check("R4 n53 zero a", 128'(p53), 128'd0);
    check("R4 n13 zero b", 128'(p13), 128'd0);
    @(posedge clk);
    a53 = 53'd1; b53 = 53'h1f_0123_4567_89ab;
    @(negedge clk);
    // R1 identity operand
    check("R1 n53 unit", 128'(p53), 128'(b53));
  endtask

  task automatic t_random;
    logic [63:0]  r;
    logic [127:0] e;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      r = {$urandom(), $urandom()}; a53 = r[52:0];
      r = {$urandom(), $urandom()}; b53 = r[52:0];
      if (k % 4 == 0) a53[52] = 1'b1;
      if (k % 4 == 1) b53[52] = 1'b0;
      r = {$urandom(), $urandom()}; a13 = r[12:0]; b13 = r[44:32];
      @(negedge clk);
      e = 128'(a53) * 128'(b53);
      // R1 and R8 with half-split core, N=53
      check("R1 R8 n53", 128'(p53), e);
      e = 128'(a13) * 128'(b13);
      // R8 flat core, N=13
      check("R8 n13", 128'(p13), e);
      // R7 top bit source
      if (!(a53[52] && b53[52])) check("R7 n53", 128'(p53[105]), 128'd0);
    end
  endtask

  task automatic t_comb;
    @(negedge clk);
    a13 = 13'd300; b13 = 13'd7;
    #2;
    // R9 product follows operands between clock edges
    check("R9 n13 first", 128'(p13), 128'd2100);
    b13 = 13'h1fff;
    #2;
    check("R9 n13 second", 128'(p13), 128'd300 * 128'd8191);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    rst_n = 1'b0;
    a5 = '0; b5 = '0; a13 = '0; b13 = '0; a53 = '0; b53 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_exhaustive5();
    t_msb_only();
    t_all_ones();
    t_zero_one();
    t_random();
    t_comb();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule